// File: doc/BRIEF.md
# Character Display Controller Instruction Core

This block is the instruction engine of a character-cell display controller. A bus front end delivers single accesses to it. Each access carries a register-select bit, a read/write bit, a byte and a one-cycle strobe. The core decodes each access as one of four kinds: an instruction, a status read, a data write or a data read. It owns the state the instruction set touches:

- a 7-bit address counter;
- a busy indication with a separate execution time per instruction;
- the entry-mode, display-control and function-set flags;
- a horizontal display offset;
- an 80-byte display text store and a 64-byte custom-glyph store.

Software writes text and glyph rows through the data register. It positions the cursor through address-set and shift instructions. Before each new command it polls the status byte until busy is clear. Data reads go through a prefetching data register. An address set or a cursor move fills that register in the background, and each read returns its contents and then refills it from the next address. Pixel generation, the character font and panel scanning live elsewhere.

Top module: `lcdc_core`

## Requirements
- R1: After reset the core is idle. The status byte reads 0x00. The 8-bit interface flag and the increment flag are 1. Two-line mode, font, display/cursor/blink, display shift, the shift offset and the overrun flag are all 0.
- R2: With register select 0 and write, the byte is decoded by its highest set bit. In the instruction with highest bit 5, bit 4 is the bus width, bit 3 is two-line mode and bit 2 is the tall font. In the instruction with highest bit 3, bits 2, 1 and 0 are display, cursor and blink. In the instruction with highest bit 2, bit 1 is increment and bit 0 is display shift. The byte 0x00 does nothing.
- R3: An accepted instruction or data access holds busy for exactly EXEC_LONG cycles for clear (0x01) and home (0x02/0x03), and for exactly EXEC_SHORT cycles otherwise. A status read (select 0, read) never raises busy.
- R4: A status read returns busy in bit 7 and the address counter in bits 6..0. It is answered even while busy.
- R5: Each data write and each data read moves the address counter by one step: up when increment is 1, down when it is 0. The new value appears in the cycle busy falls, and the counter holds while busy.
- R6: Instruction 1xxxxxxx loads the counter with bits 6..0 and routes data accesses to the text store. Instruction 01xxxxxx loads the 6-bit glyph address and routes data accesses to the glyph store. While the glyph store is selected, counter bit 6 is 0.
- R7: A data read returns the data register and then refills it from the stepped address. After an address set, reads return consecutive store bytes. A read that directly follows a data write returns the byte just written.
- R8: In two-line mode each text line wraps inside its own range: 0x27 steps up to 0x00, 0x67 steps up to 0x40, and the reverse on a down step. In one-line mode 0x4F and 0x00 wrap into each other.
- R9: With display shift set, a text-store write also moves the shift offset (range 0..39, wrapping): +1 when increment is 1, -1 when it is 0. Data reads and glyph-store writes leave the offset alone.
- R10: In the instruction with highest bit 4, bit 3 = 0 moves the cursor (bit 2 = 0 gives -1, bit 2 = 1 gives +1) and refills the data register from the new address. Bit 3 = 1 moves the offset (bit 2 = 0 gives +1, bit 2 = 1 gives -1) and keeps the counter.
- R11: Clear sets every text byte to 0x20, the counter to 0x00, increment to 1 and the offset to 0, and selects the text store.
- R12: Home sets the counter and the offset to 0 and selects the text store. Stored text is kept.
- R13: Any access other than a status read that arrives while busy is dropped: no store, counter or flag changes. It sets the overrun flag, which stays set until reset.
- R14: The glyph store keeps all 8 bits of each byte, and its 6-bit address wraps 0x3F to 0x00 and back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | One-cycle access strobe |
| acc_rs | input | 1 | 0 = instruction/status, 1 = data |
| acc_rw | input | 1 | 0 = write, 1 = read |
| acc_wdata | input | 8 | Instruction or data byte |
| rd_data | output | 8 | Byte returned by the last read, valid the cycle after the strobe |
| busy | output | 1 | Internal operation in progress |
| overrun | output | 1 | Sticky: an access was dropped while busy |
| addr_cnt | output | 7 | Address counter |
| ram_sel_cg | output | 1 | 1 = data accesses target the glyph store |
| entry_inc | output | 1 | Address step direction (1 = up) |
| entry_shift | output | 1 | Display shift on text writes |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| bus_8bit | output | 1 | Interface width flag |
| two_line | output | 1 | Two-line addressing |
| font_tall | output | 1 | Tall font flag |
| shift_ofs | output | 6 | Display shift offset, 0..39 |

## Verification
The assertions assume a strobe lasts a single cycle and that the front end presents the select, direction and byte with it. Under that assumption the only legal state change while busy is the completion step on the falling edge of busy. The bench drives each access for one cycle between falling clock edges, then waits until busy drops before the next one. The overrun case is the exception: it deliberately sends back-to-back strobes while busy. The bench does not rely on text addresses outside the two line ranges.

// File: rtl/lcdc_pkg.sv
`timescale 1ns/1ps
package lcdc_pkg;

  localparam int LINE_LEN  = 40;
  localparam int TEXT_SLOTS = 2 * LINE_LEN;
  localparam int GLYPH_SLOTS = 64;
  localparam logic [7:0] BLANK = 8'h20;
  localparam logic [6:0] NO_SLOT = 7'h7F;

  typedef enum logic [3:0] {
    OP_NOP, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISPCTL, OP_SHIFT, OP_FUNC,
    OP_CGADDR, OP_DDADDR, OP_WRDATA, OP_RDDATA, OP_STATUS
  } op_e;

  // One address step with per-store and per-line wrapping.
  function automatic logic [6:0] ac_step(input logic [6:0] ac, input logic up,
                                         input logic cg, input logic two);
    logic [6:0] col;
    if (cg) return {1'b0, ac[5:0] + (up ? 6'd1 : 6'h3F)};
    if (two) begin
      col = {1'b0, ac[5:0]};
      if (up) col = (col >= 7'(LINE_LEN - 1)) ? 7'd0 : col + 7'd1;
      else    col = (col == 7'd0 || col > 7'(LINE_LEN - 1)) ? 7'(LINE_LEN - 1) : col - 7'd1;
      return {ac[6], 6'd0} | col;
    end
    if (up) return (ac >= 7'(TEXT_SLOTS - 1)) ? 7'd0 : ac + 7'd1;
    return (ac == 7'd0 || ac > 7'(TEXT_SLOTS - 1)) ? 7'(TEXT_SLOTS - 1) : ac - 7'd1;
  endfunction

  // Text-store slot for an address, NO_SLOT when outside the mapped ranges.
  function automatic logic [6:0] text_slot(input logic [6:0] ac, input logic two);
    if (two) begin
      if (ac[5:0] >= 6'(LINE_LEN)) return NO_SLOT;
      return ac[6] ? 7'(LINE_LEN) + {1'b0, ac[5:0]} : {1'b0, ac[5:0]};
    end
    return (ac < 7'(TEXT_SLOTS)) ? ac : NO_SLOT;
  endfunction

  // Display offset step; left = +1.
  function automatic logic [5:0] ofs_step(input logic [5:0] ofs, input logic left);
    if (left) return (ofs >= 6'(LINE_LEN - 1)) ? 6'd0 : ofs + 6'd1;
    return (ofs == 6'd0 || ofs > 6'(LINE_LEN - 1)) ? 6'(LINE_LEN - 1) : ofs - 6'd1;
  endfunction

endpackage

// File: rtl/lcdc_decode.sv
`timescale 1ns/1ps
module lcdc_decode
  import lcdc_pkg::*;
(
  input  logic       rs,
  input  logic       rw,
  input  logic [7:0] code,
  output op_e        op
);
  always_comb begin
    if (rs)      op = rw ? OP_RDDATA : OP_WRDATA;
    else if (rw) op = OP_STATUS;
    else begin
      casez (code)
        8'b1???????: op = OP_DDADDR;
        8'b01??????: op = OP_CGADDR;
        8'b001?????: op = OP_FUNC;
        8'b0001????: op = OP_SHIFT;
        8'b00001???: op = OP_DISPCTL;
        8'b000001??: op = OP_ENTRY;
        8'b0000001?: op = OP_HOME;
        8'b00000001: op = OP_CLEAR;
        default:     op = OP_NOP;
      endcase
    end
  end
endmodule

// File: rtl/lcdc_busy_timer.sv
`timescale 1ns/1ps
module lcdc_busy_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= len;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));
endmodule

// File: rtl/lcdc_store.sv
`timescale 1ns/1ps
module lcdc_store
  import lcdc_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic       dd_we,
  input  logic [6:0] dd_idx,
  input  logic       cg_we,
  input  logic [5:0] cg_idx,
  input  logic [7:0] wdata,
  input  logic       rd_cg,
  input  logic [6:0] rd_dd_idx,
  input  logic [5:0] rd_cg_idx,
  output logic [7:0] rdata
);
  logic [7:0] dd_q [TEXT_SLOTS];
  logic [7:0] cg_q [GLYPH_SLOTS];
  logic [TEXT_SLOTS-1:0] cell_we;

  for (genvar i = 0; i < TEXT_SLOTS; i++) begin : g_cell_we
    assign cell_we[i] = dd_we && (dd_idx == 7'(i));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < TEXT_SLOTS; i++) begin
      if (clr)             dd_q[i] <= BLANK;
      else if (cell_we[i]) dd_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (cg_we) cg_q[cg_idx] <= wdata;
  end

  always_comb begin
    if (rd_cg)                          rdata = cg_q[rd_cg_idx];
    else if (rd_dd_idx < 7'(TEXT_SLOTS)) rdata = dd_q[rd_dd_idx];
    else                                rdata = 8'h00;
  end
endmodule

// File: rtl/lcdc_core.sv
`timescale 1ns/1ps
module lcdc_core
  import lcdc_pkg::*;
#(
  parameter int EXEC_SHORT = 4,
  parameter int EXEC_LONG  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic       acc_rs,
  input  logic       acc_rw,
  input  logic [7:0] acc_wdata,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       overrun,
  output logic [6:0] addr_cnt,
  output logic       ram_sel_cg,
  output logic       entry_inc,
  output logic       entry_shift,
  output logic       disp_on,
  output logic       cursor_on,
  output logic       blink_on,
  output logic       bus_8bit,
  output logic       two_line,
  output logic       font_tall,
  output logic [5:0] shift_ofs
);
  localparam int TMAX = (EXEC_LONG > EXEC_SHORT) ? EXEC_LONG : EXEC_SHORT;
  localparam int CW   = $clog2(TMAX + 1);

  op_e         op;
  logic        evt_accept, evt_reject, evt_done, is_status;
  logic [CW-1:0] exec_len;
  logic        pend_step, pend_up, pend_fetch;
  logic [6:0]  ac_fin;
  logic [7:0]  dreg, store_rdata;
  logic        st_clr, st_dd_we, st_cg_we;

  lcdc_decode u_dec (.rs(acc_rs), .rw(acc_rw), .code(acc_wdata), .op(op));

  assign is_status  = (op == OP_STATUS);
  assign evt_accept = acc_valid && !busy && !is_status && (op != OP_NOP);
  assign evt_reject = acc_valid && busy && !is_status;
  assign exec_len   = (op == OP_CLEAR || op == OP_HOME) ? CW'(EXEC_LONG) : CW'(EXEC_SHORT);

  lcdc_busy_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(evt_accept), .len(exec_len),
    .busy(busy), .done(evt_done)
  );

  // Counter value at the end of the current operation; the refill reads there.
  assign ac_fin   = pend_step ? ac_step(addr_cnt, pend_up, ram_sel_cg, two_line) : addr_cnt;
  assign st_clr   = evt_accept && (op == OP_CLEAR);
  assign st_dd_we = evt_accept && (op == OP_WRDATA) && !ram_sel_cg;
  assign st_cg_we = evt_accept && (op == OP_WRDATA) && ram_sel_cg;

  lcdc_store u_store (
    .clk(clk), .clr(st_clr),
    .dd_we(st_dd_we), .dd_idx(text_slot(addr_cnt, two_line)),
    .cg_we(st_cg_we), .cg_idx(addr_cnt[5:0]), .wdata(acc_wdata),
    .rd_cg(ram_sel_cg), .rd_dd_idx(text_slot(ac_fin, two_line)),
    .rd_cg_idx(ac_fin[5:0]), .rdata(store_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_cnt <= '0;  ram_sel_cg <= 1'b0;
      entry_inc <= 1'b1; entry_shift <= 1'b0;
      disp_on <= 1'b0; cursor_on <= 1'b0; blink_on <= 1'b0;
      bus_8bit <= 1'b1; two_line <= 1'b0; font_tall <= 1'b0;
      shift_ofs <= '0; dreg <= '0; rd_data <= '0; overrun <= 1'b0;
      pend_step <= 1'b0; pend_up <= 1'b0; pend_fetch <= 1'b0;
    end else begin
      if (evt_reject) overrun <= 1'b1;
      if (acc_valid && is_status) rd_data <= {busy, addr_cnt};
      if (evt_done) begin
        addr_cnt <= ac_fin;
        if (pend_fetch) dreg <= store_rdata;
        pend_step  <= 1'b0;
        pend_fetch <= 1'b0;
      end
      if (evt_accept) begin
        unique case (op)
          OP_CLEAR: begin
            addr_cnt <= '0; ram_sel_cg <= 1'b0; entry_inc <= 1'b1; shift_ofs <= '0;
          end
          OP_HOME: begin
            addr_cnt <= '0; ram_sel_cg <= 1'b0; shift_ofs <= '0;
          end
          OP_ENTRY: begin
            entry_inc <= acc_wdata[1]; entry_shift <= acc_wdata[0];
          end
          OP_DISPCTL: begin
            disp_on <= acc_wdata[2]; cursor_on <= acc_wdata[1]; blink_on <= acc_wdata[0];
          end
          OP_SHIFT: begin
            if (acc_wdata[3]) shift_ofs <= ofs_step(shift_ofs, !acc_wdata[2]);
            else begin
              pend_step <= 1'b1; pend_up <= acc_wdata[2]; pend_fetch <= 1'b1;
            end
          end
          OP_FUNC: begin
            bus_8bit <= acc_wdata[4]; two_line <= acc_wdata[3]; font_tall <= acc_wdata[2];
          end
          OP_CGADDR: begin
            addr_cnt <= {1'b0, acc_wdata[5:0]}; ram_sel_cg <= 1'b1; pend_fetch <= 1'b1;
          end
          OP_DDADDR: begin
            addr_cnt <= acc_wdata[6:0]; ram_sel_cg <= 1'b0; pend_fetch <= 1'b1;
          end
          OP_WRDATA: begin
            dreg <= acc_wdata; pend_step <= 1'b1; pend_up <= entry_inc;
            if (entry_shift && !ram_sel_cg) shift_ofs <= ofs_step(shift_ofs, entry_inc);
          end
          OP_RDDATA: begin
            rd_data <= dreg; pend_step <= 1'b1; pend_up <= entry_inc; pend_fetch <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcdc_core_chk.sv
`timescale 1ns/1ps
module lcdc_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       acc_rs,
  input logic       acc_rw,
  input logic       busy,
  input logic       overrun,
  input logic [6:0] addr_cnt,
  input logic       ram_sel_cg,
  input logic [5:0] shift_ofs,
  input logic       evt_accept,
  input logic       evt_reject,
  input logic       evt_done
);
  p_accept_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> busy);
  p_done_ends_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> !busy);
  p_status_no_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_rs && acc_rw && !busy) |=> !busy);
  p_ac_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !evt_done) |=> $stable(addr_cnt));
  p_glyph_ac_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_sel_cg |-> !addr_cnt[6]);
  p_ofs_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ofs < 6'd40);
  p_reject_flags_r13: assert property (@(posedge clk) disable iff (!rst_n)
    evt_reject |=> overrun);
  p_overrun_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

bind lcdc_core lcdc_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_rs(acc_rs), .acc_rw(acc_rw),
  .busy(busy), .overrun(overrun), .addr_cnt(addr_cnt), .ram_sel_cg(ram_sel_cg),
  .shift_ofs(shift_ofs), .evt_accept(evt_accept), .evt_reject(evt_reject),
  .evt_done(evt_done)
);

// File: tb/lcdc_core_tb.sv
`timescale 1ns/1ps
module lcdc_core_tb;
  localparam int TS = 4;
  localparam int TL = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_rs = 1'b0, acc_rw = 1'b0;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] rd_data;
  logic busy, overrun, ram_sel_cg, entry_inc, entry_shift, disp_on, cursor_on, blink_on;
  logic bus_8bit, two_line, font_tall;
  logic [6:0] addr_cnt;
  logic [5:0] shift_ofs;

  always #4 clk = ~clk;

  lcdc_core #(.EXEC_SHORT(TS), .EXEC_LONG(TL)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_rs(acc_rs), .acc_rw(acc_rw),
    .acc_wdata(acc_wdata), .rd_data(rd_data), .busy(busy), .overrun(overrun),
    .addr_cnt(addr_cnt), .ram_sel_cg(ram_sel_cg), .entry_inc(entry_inc),
    .entry_shift(entry_shift), .disp_on(disp_on), .cursor_on(cursor_on),
    .blink_on(blink_on), .bus_8bit(bus_8bit), .two_line(two_line),
    .font_tall(font_tall), .shift_ofs(shift_ofs)
  );

  int n_vec = 0, n_bad = 0;
  logic [7:0] txt_m [80];
  logic [7:0] st, rv;
  logic two_m = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int slot_of(input int a, input logic two);
    return two ? (a / 64) * 40 + (a % 64) : a;
  endfunction

  function automatic int next_ac(input int a, input logic up, input logic two);
    int col;
    if (!two) return (a + (up ? 1 : 79)) % 80;
    col = ((a % 64) + (up ? 1 : 39)) % 40;
    return (a / 64) * 64 + col;
  endfunction

  // One access; waits for busy to fall and returns the busy length and read byte.
  task automatic access(input logic rs, input logic rw, input logic [7:0] d,
                        output int blen, output logic [7:0] r);
    @(negedge clk);
    acc_valid = 1'b1; acc_rs = rs; acc_rw = rw; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0;
    r = rd_data;
    blen = 0;
    while (busy && blen < 1000) begin
      blen++;
      @(negedge clk);
    end
  endtask

  task automatic ins(input logic [7:0] d);
    int bl; logic [7:0] r;
    access(1'b0, 1'b0, d, bl, r);
    chk("R3 busy length", bl, (d == 8'h01 || d[7:1] == 7'h01) ? TL : TS);
  endtask

  task automatic wr(input logic [7:0] d);
    int bl; logic [7:0] r;
    access(1'b1, 1'b0, d, bl, r);
    chk("R3 write busy length", bl, TS);
  endtask

  task automatic rdd(output logic [7:0] d);
    int bl;
    access(1'b1, 1'b1, 8'h00, bl, d);
  endtask

  task automatic status(output logic [7:0] s);
    int bl;
    access(1'b0, 1'b1, 8'h00, bl, s);
    chk("R3 status read leaves busy low", bl, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int a, v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 inc", entry_inc, 1);
    chk("R1 bus8", bus_8bit, 1);
    chk("R1 two_line", two_line, 0);
    chk("R1 display flags", {disp_on, cursor_on, blink_on, entry_shift, font_tall}, 0);
    chk("R1 shift_ofs", shift_ofs, 0);
    status(st); chk("R1 status byte", st, 8'h00);

    // R2 decode of flag instructions
    ins(8'h28); chk("R2 func 0x28", {bus_8bit, two_line, font_tall}, 3'b010);
    ins(8'h34); chk("R2 func 0x34", {bus_8bit, two_line, font_tall}, 3'b101);
    ins(8'h38); chk("R2 func 0x38", {bus_8bit, two_line, font_tall}, 3'b110);
    two_m = 1'b1;
    ins(8'h0D); chk("R2 dispctl 0x0D", {disp_on, cursor_on, blink_on}, 3'b101);
    ins(8'h0E); chk("R2 dispctl 0x0E", {disp_on, cursor_on, blink_on}, 3'b110);
    ins(8'h04); chk("R2 entry 0x04", {entry_inc, entry_shift}, 2'b00);
    ins(8'h06); chk("R2 entry 0x06", {entry_inc, entry_shift}, 2'b10);
    begin
      int bl; logic [7:0] r;
      access(1'b0, 1'b0, 8'h00, bl, r);
      chk("R2 code 0x00 is no-op", bl, 0);
    end

    ins(8'h01);
    for (int i = 0; i < 80; i++) txt_m[i] = 8'h20;
    status(st); chk("R11 clear counter", st, 8'h00);

    // R5/R8 write sweep over both lines with wrapping
    for (int ln = 0; ln < 2; ln++) begin
      ins(8'h80 | 8'(ln * 64));
      for (int i = 0; i < 40; i++) begin
        a = ln * 64 + i;
        v = (a * 37 + 11) % 256;
        wr(8'(v));
        txt_m[slot_of(a, 1'b1)] = 8'(v);
        status(st);
        chk("R5 R8 counter after write", st, next_ac(a, 1'b1, 1'b1));
      end
    end

    // R7 read-back sweep
    for (int ln = 0; ln < 2; ln++) begin
      ins(8'h80 | 8'(ln * 64));
      status(st); chk("R6 address set", st, ln * 64);
      for (int i = 0; i < 40; i++) begin
        rdd(rv);
        chk("R7 sequential read", rv, txt_m[slot_of(ln * 64 + i, 1'b1)]);
      end
      status(st); chk("R8 read wrap up", st, ln * 64);
    end

    // R8 down-step wrapping
    ins(8'h04);
    ins(8'h80); rdd(rv); chk("R7 read at 0x00", rv, txt_m[0]);
    status(st); chk("R8 0x00 down to 0x27", st, 8'h27);
    rdd(rv); chk("R7 read at 0x27", rv, txt_m[slot_of(8'h27, 1'b1)]);
    ins(8'hC0); rdd(rv);
    status(st); chk("R8 0x40 down to 0x67", st, 8'h67);

    // R7 read after write returns written byte
    ins(8'h06); ins(8'h85); wr(8'hA7); txt_m[5] = 8'hA7;
    status(st); chk("R5 counter after write", st, 8'h06);
    rdd(rv); chk("R7 read after write", rv, 8'hA7);
    rdd(rv); chk("R7 next read refilled", rv, txt_m[7]);

    // R9 display shift on writes
    ins(8'h90); ins(8'h07); wr(8'h31); txt_m[16] = 8'h31;
    chk("R9 shift left on write", shift_ofs, 1);
    ins(8'h05); wr(8'h32); txt_m[17] = 8'h32;
    chk("R9 shift right on write", shift_ofs, 0);
    wr(8'h33); txt_m[16] = 8'h33;
    chk("R9 shift right wrap", shift_ofs, 39);
    rdd(rv); chk("R9 read keeps offset", shift_ofs, 39);
    ins(8'h40); wr(8'h15);
    chk("R9 glyph write keeps offset", shift_ofs, 39);
    status(st); chk("R14 glyph down wrap", st, 8'h3F);

    // R10 shift instruction
    ins(8'h06); ins(8'hA0);
    ins(8'h10); status(st); chk("R10 cursor left", st, 8'h1F);
    ins(8'h14); status(st); chk("R10 cursor right", st, 8'h20);
    ins(8'h14); rdd(rv); chk("R10 cursor move refills", rv, txt_m[33]);
    ins(8'h18); chk("R10 display left", shift_ofs, 0);
    status(st); chk("R10 display shift keeps counter", st, 8'h22);
    ins(8'h1C); chk("R10 display right", shift_ofs, 39);
    ins(8'h1C); chk("R10 display right again", shift_ofs, 38);

    // R6/R14 glyph store
    ins(8'h7E); chk("R6 glyph select", ram_sel_cg, 1);
    wr(8'h11); wr(8'hE2);
    status(st); chk("R14 glyph up wrap", st, 8'h00);
    ins(8'h7E); rdd(rv); chk("R14 glyph byte", rv, 8'h11);
    rdd(rv); chk("R14 glyph full 8 bits", rv, 8'hE2);

    // R12 home
    ins(8'h02);
    status(st); chk("R12 home counter", st, 8'h00);
    chk("R12 home offset", shift_ofs, 0);
    chk("R12 home selects text", ram_sel_cg, 0);
    ins(8'h80); rdd(rv); chk("R12 text kept", rv, txt_m[0]);

    // R13 overrun: write while busy is dropped, status still answered
    @(negedge clk); acc_valid = 1'b1; acc_rs = 1'b0; acc_rw = 1'b0; acc_wdata = 8'h8A;
    @(negedge clk); acc_rs = 1'b1; acc_rw = 1'b0; acc_wdata = 8'h5C;
    @(negedge clk); acc_rs = 1'b0; acc_rw = 1'b1; acc_wdata = 8'h00;
    @(negedge clk); acc_valid = 1'b0;
    chk("R4 busy bit in status", rd_data, 8'h8A);
    chk("R13 overrun set", overrun, 1);
    while (busy) @(negedge clk);
    status(st); chk("R13 dropped write kept counter", st, 8'h0A);
    rdd(rv); chk("R13 dropped write kept text", rv, txt_m[10]);
    chk("R13 overrun sticky", overrun, 1);

    // R11 clear
    ins(8'h04); ins(8'h1C); ins(8'h01);
    for (int i = 0; i < 80; i++) txt_m[i] = 8'h20;
    chk("R11 clear forces increment", entry_inc, 1);
    chk("R11 clear offset", shift_ofs, 0);
    status(st); chk("R11 clear counter zero", st, 8'h00);
    for (int ln = 0; ln < 2; ln++) begin
      ins(8'h80 | 8'(ln * 64));
      for (int i = 0; i < 40; i++) begin
        rdd(rv); chk("R11 blank fill", rv, 8'h20);
      end
    end

    // R8 one-line wrap
    ins(8'h30); two_m = 1'b0;
    ins(8'hCF); wr(8'h77); txt_m[79] = 8'h77;
    status(st); chk("R8 one-line 0x4F up to 0x00", st, 8'h00);
    ins(8'h04); ins(8'h80); rdd(rv); chk("R7 one-line read 0x00", rv, 8'h20);
    status(st); chk("R8 one-line 0x00 down to 0x4F", st, 8'h4F);
    rdd(rv); chk("R8 one-line read 0x4F", rv, txt_m[slot_of(8'h4F, two_m)]);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule